// File: doc/BRIEF.md
# Serial Pattern Detector with Permanent Halt

This block watches a one-bit serial stream, taking one bit on every rising clock edge. It is a Moore machine with seven states. Its `detect` output goes high for one state whenever the three most recent bits are 0, 1, 0. Matches may overlap, so a stream of 0,1,0,1,0 produces two detections.

In parallel, the machine looks for the bit pattern 1, 0, 0. When that pattern arrives, including when it shares bits with a 0,1,0 match, the machine drops into a trap state. From then on it ignores its input and holds `detect` low until reset is asserted.

Reset is asynchronous and active high. The current 3-bit state code is brought out on a port so that a test fixture or a logic analyser can follow the machine step by step.

Top module: `seqdet_halt`

## Requirements
- R1: Asserting `rst` moves the machine to state code 0 and drives `detect` low at once, without waiting for a clock edge.
- R2: The state codes are fixed: 0 means no bits yet, 1 means the last bit was 0 with no 1 before it, 2 means the last two bits were 0,1, 3 means 0,1,0 has just matched, 4 means the last bit was 1 (after 1,1 or a first 1), 5 means the last two bits were 1,0 with no 0 before them, and 6 means halted. Code 7 never appears.
- R3: `detect` is high in the cycle after the third bit of a 0,1,0 match has been sampled, as long as no 1,0,0 has occurred since reset. In every other case it is low.
- R4: Detection overlaps: with the input 0,1,0,1,0, `detect` is high after the third bit and again after the fifth bit.
- R5: The first time 1,0,0 appears among the bits taken since reset, the state code becomes 6. This also holds when the pattern overlaps a 0,1,0 match, as in 0,1,0,0.
- R6: In state code 6, any input value leaves the machine in code 6 with `detect` low.
- R7: Only reset leaves state code 6. After reset, detection works again as described in R3.
- R8: `detect` is high only in state code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `din` is sampled on the rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| din | input | 1 | Serial input bit |
| detect | output | 1 | High while the machine is in the 0,1,0-matched state |
| state_code | output | 3 | Current state code, for observation |

## Verification
The bench applies every bit string of length one to six, starting from reset each time. This exercises every transition arc, and it compares the state code and `detect` after every clock against values it derives from the input history.

The cases it targets are these:
- Overlapping 0,1,0 matches. A design that cleared its history after a match would miss the second detection.
- The string 0,1,0,0. A design that tracked the two patterns separately would leave this string in state 5 instead of halting.
- Input that keeps arriving after a halt. A halt state that is not truly absorbing would let a later 0,1,0 fire.
- A reset raised in the middle of a cycle. A reset synchronous to the clock would leave the old state visible until the next edge.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 3'd0,
        ST_Z    = 3'd1,
        ST_ZO   = 3'd2,
        ST_HIT  = 3'd3,
        ST_O    = 3'd4,
        ST_OZ   = 3'd5,
        ST_HALT = 3'd6
    } seq_state_e;

    // Next state for one sampled bit.
    function automatic seq_state_e step_state(seq_state_e cur, logic bit_in);
        seq_state_e nxt;
        case (cur)
            ST_IDLE: nxt = bit_in ? ST_O  : ST_Z;
            ST_Z:    nxt = bit_in ? ST_ZO : ST_Z;
            ST_ZO:   nxt = bit_in ? ST_O  : ST_HIT;
            ST_HIT:  nxt = bit_in ? ST_ZO : ST_HALT;
            ST_O:    nxt = bit_in ? ST_O  : ST_OZ;
            ST_OZ:   nxt = bit_in ? ST_ZO : ST_HALT;
            ST_HALT: nxt = ST_HALT;
            default: nxt = ST_HALT;
        endcase
        return nxt;
    endfunction

    function automatic logic state_fires(seq_state_e s);
        return (s == ST_HIT);
    endfunction

endpackage

// File: rtl/seqdet_next.sv
module seqdet_next (
    input  seqdet_pkg::seq_state_e cur,
    input  logic                   din,
    output seqdet_pkg::seq_state_e nxt
);
    always_comb begin
        nxt = seqdet_pkg::step_state(cur, din);
    end
endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg #(
    parameter seqdet_pkg::seq_state_e RESET_STATE = seqdet_pkg::ST_IDLE
) (
    input  logic                   clk,
    input  logic                   rst,
    input  seqdet_pkg::seq_state_e nxt,
    output seqdet_pkg::seq_state_e cur
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cur <= RESET_STATE;
        end else begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/seqdet_out.sv
module seqdet_out (
    input  seqdet_pkg::seq_state_e          cur,
    output logic                            detect,
    output logic [seqdet_pkg::STATE_W-1:0]  state_code
);
    always_comb begin
        detect     = seqdet_pkg::state_fires(cur);
        state_code = cur;
    end
endmodule

// File: rtl/seqdet_halt.sv
module seqdet_halt (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    output logic       detect,
    output logic [2:0] state_code
);
    seqdet_pkg::seq_state_e cur_q;
    seqdet_pkg::seq_state_e nxt_d;

    seqdet_next next_i (
        .cur (cur_q),
        .din (din),
        .nxt (nxt_d)
    );

    seqdet_state_reg #(
        .RESET_STATE (seqdet_pkg::ST_IDLE)
    ) reg_i (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_d),
        .cur (cur_q)
    );

    seqdet_out out_i (
        .cur        (cur_q),
        .detect     (detect),
        .state_code (state_code)
    );
endmodule

// File: rtl/seqdet_halt_chk.sv
module seqdet_halt_chk (
    input logic       clk,
    input logic       rst,
    input logic       din,
    input logic       detect,
    input logic [2:0] state_code
);
    // R2
    code_range_chk: assert property (@(posedge clk) disable iff (rst)
        state_code != 3'd7);

    // R8
    detect_code_chk: assert property (@(posedge clk) disable iff (rst)
        detect |-> state_code == 3'd3);

    // R3
    match_fires_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd2 && !din) |=> detect);

    // R5
    overlap_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd3 && !din) |=> state_code == 3'd6);

    // R5
    plain_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd5 && !din) |=> state_code == 3'd6);

    // R6
    halt_stays_chk: assert property (@(posedge clk) disable iff (rst)
        state_code == 3'd6 |=> state_code == 3'd6);

    // R6
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        state_code == 3'd6 |-> !detect);

    // R4
    overlap_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (detect && din) |=> state_code == 3'd2);
endmodule

bind seqdet_halt seqdet_halt_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .din        (din),
    .detect     (detect),
    .state_code (state_code)
);

// File: tb/seqdet_halt_tb.sv
module seqdet_halt_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       din;
    logic       detect;
    logic [2:0] state_code;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Reference history kept by the bench
    logic [2:0] hist;
    int         nbits;
    bit         halted;

    always #10 clk = ~clk;

    seqdet_halt dut_i (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .detect     (detect),
        .state_code (state_code)
    );

    function automatic logic [2:0] exp_state(logic [2:0] h, int n, bit hl);
        if (hl) return 3'd6;
        if (n == 0) return 3'd0;
        if (!h[0]) begin
            if (n >= 2 && h[1]) return (n >= 3 && !h[2]) ? 3'd3 : 3'd5;
            return 3'd1;
        end
        return (n >= 2 && !h[1]) ? 3'd2 : 3'd4;
    endfunction

    function automatic logic exp_detect(logic [2:0] h, int n, bit hl);
        return !hl && n >= 3 && h == 3'b010;
    endfunction

    task automatic check(string req, logic [2:0] es, logic ed);
        checks++;
        if (state_code !== es || detect !== ed) begin
            errors++;
            $display("FAIL %s: state=%0d detect=%0b expected state=%0d detect=%0b",
                     req, state_code, detect, es, ed);
        end
    endtask

    task automatic model_clear();
        hist = 3'b000; nbits = 0; halted = 1'b0;
    endtask

    task automatic model_push(logic b);
        if (!halted) begin
            hist = {hist[1:0], b};
            nbits++;
            if (nbits >= 3 && hist == 3'b100) halted = 1'b1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        check("R1 reset state", 3'd0, 1'b0);
    endtask

    task automatic step(logic b, string req);
        din = b;
        @(posedge clk);
        @(negedge clk);
        model_push(b);
        check(req, exp_state(hist, nbits, halted), exp_detect(hist, nbits, halted));
    endtask

    initial begin
        rst = 1'b1;
        din = 1'b0;
        model_clear();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 power-on reset", 3'd0, 1'b0);

        // R4: overlapping matches
        step(1'b0, "R4"); step(1'b1, "R4"); step(1'b0, "R4 first hit");
        step(1'b1, "R4"); step(1'b0, "R4 second hit");
        // R5: overlapping 0,1,0,0 halts
        step(1'b0, "R5 overlap halt");
        // R6: halt ignores input
        step(1'b0, "R6"); step(1'b1, "R6"); step(1'b0, "R6 no detect");

        // R1: asynchronous reset mid-cycle
        #4 rst = 1'b1;
        #1 model_clear();
        check("R1 async reset", 3'd0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        // R7: detection resumes after leaving halt
        step(1'b0, "R7"); step(1'b1, "R7"); step(1'b0, "R7 resumed hit");

        // R2 R3 R5 R6: every input string of length 1..6 from reset
        for (int len = 1; len <= 6; len++) begin
            for (int pat = 0; pat < (1 << len); pat++) begin
                do_reset();
                for (int i = len - 1; i >= 0; i--) begin
                    step(pat[i], "R2/R3 sweep");
                end
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule